// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Unit

This block gives the two ports of a shared synchronous RAM a way to signal each other. The two highest word addresses are reserved as mailboxes, one owned by each port. When one port writes into the mailbox owned by the other port, an interrupt is raised to the owner. The owner acknowledges by reading its own mailbox, which drops the interrupt. The message word itself sits in the RAM like any other data, and the interrupt logic never looks at it.

Port A is the left port and owns address `2**AW-2`. Port B is the right port and owns address `2**AW-1`. Each port has its own busy input, which comes from an arbiter outside this block. While a port's busy input is high, that port can neither raise the other port's interrupt nor clear its own. Reset leaves both interrupts pending, so start-up software has to read each mailbox once before it can rely on the interrupt lines.

Top module: `mailbox_irq`

## Requirements
- R1: While reset is active and after reset, `irqAN` and `irqBN` are 0 (pending) and both read-data outputs are 0.
- R2: When port A writes address `2**AW-1` with `busyA` low, `irqBN` goes to 0 after the next rising clock edge. When port B writes address `2**AW-2` with `busyB` low, `irqAN` goes to 0 after that same edge.
- R3: When a port reads its own mailbox with its busy input low, its interrupt output goes to 1 after the next rising edge.
- R4: When a port reads the other port's mailbox, the other port's interrupt does not change.
- R5: When a port writes the other port's mailbox while its own busy input is high, the other port's interrupt does not change.
- R6: When a port reads its own mailbox while its own busy input is high, its interrupt does not change.
- R7: A read is an access with `en`=1, `oe`=1 and `wr`=0. A write is an access with `en`=1 and `wr`=1. A mailbox read with `oe`=0 does not clear the interrupt. A write with `en`=0 neither sets an interrupt nor changes RAM contents.
- R8: If the same interrupt is set and cleared in one cycle, the set wins and the output becomes 0.
- R9: A word written by either port is stored and can be read by either port. Read data is registered and appears after the rising edge on which the read is taken. Mailbox words are stored like any other data.
- R10: When a port writes its own mailbox, its own interrupt does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| enA | input | 1 | Port A enable |
| wrA | input | 1 | Port A direction: 1 = write, 0 = read |
| oeA | input | 1 | Port A output enable |
| busyA | input | 1 | Port A has lost arbitration |
| addrA | input | AW | Port A word address |
| wdataA | input | DW | Port A write data |
| rdataA | output | DW | Port A registered read data |
| irqAN | output | 1 | Interrupt to port A, active low |
| enB | input | 1 | Port B enable |
| wrB | input | 1 | Port B direction: 1 = write, 0 = read |
| oeB | input | 1 | Port B output enable |
| busyB | input | 1 | Port B has lost arbitration |
| addrB | input | AW | Port B word address |
| wdataB | input | DW | Port B write data |
| rdataB | output | DW | Port B registered read data |
| irqBN | output | 1 | Interrupt to port B, active low |

## Verification
A raise and an acknowledge of the same interrupt can happen in the same cycle. This occurs when port A writes port B's mailbox on the same edge that port B reads it. The bench drives both accesses on one edge and expects `irqBN` to end at 0. It then repeats the read alone and expects `irqBN` to go to 1, with the newly written word on `rdataB`.

// File: rtl/mailbox_irq_pkg.sv
package mailbox_irq_pkg;
  // Strobes from the decode logic to the datapath
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic rdA;
    logic rdB;
    logic setA;   // raise interrupt to port A
    logic clrA;   // acknowledge by port A
    logic setB;
    logic clrB;
  } strobe_t;
endpackage

// File: rtl/mailbox_ctrl.sv
module mailbox_ctrl
  import mailbox_irq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          enA,
  input  logic          wrA,
  input  logic          oeA,
  input  logic          busyA,
  input  logic [AW-1:0] addrA,
  input  logic          enB,
  input  logic          wrB,
  input  logic          oeB,
  input  logic          busyB,
  input  logic [AW-1:0] addrB,
  output strobe_t       stb
);
  localparam logic [AW-1:0] BOX_B = {AW{1'b1}};        // top word
  localparam logic [AW-1:0] BOX_A = BOX_B - 1'b1;      // next word down

  logic writeA, readA, writeB, readB;

  always_comb begin
    writeA = enA & wrA;
    readA  = enA & oeA & ~wrA;
    writeB = enB & wrB;
    readB  = enB & oeB & ~wrB;

    stb.wrA  = writeA;
    stb.wrB  = writeB;
    stb.rdA  = readA;
    stb.rdB  = readB;
    stb.setA = writeB & (addrB == BOX_A) & ~busyB;
    stb.clrA = readA  & (addrA == BOX_A) & ~busyA;
    stb.setB = writeA & (addrA == BOX_B) & ~busyA;
    stb.clrB = readB  & (addrB == BOX_B) & ~busyB;
  end
endmodule

// File: rtl/mailbox_dpath.sv
module mailbox_dpath
  import mailbox_irq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] addrA,
  input  logic [DW-1:0] wdataA,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] wdataB,
  output logic [DW-1:0] rdataA,
  output logic [DW-1:0] rdataB,
  output logic          irqAN,
  output logic          irqBN
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    pend;
  logic [1:0]    setV, clrV;

  // Storage: port B write is applied last on an address collision
  always_ff @(posedge clk) begin
    if (stb.wrA) mem[addrA] <= wdataA;
    if (stb.wrB) mem[addrB] <= wdataB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataA <= '0;
      rdataB <= '0;
    end else begin
      if (stb.rdA) rdataA <= mem[addrA];
      if (stb.rdB) rdataB <= mem[addrB];
    end
  end

  assign setV = {stb.setB, stb.setA};
  assign clrV = {stb.clrB, stb.clrA};

  // One pending flag per port; a raise overrides an acknowledge
  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)        pend[i] <= 1'b1;
      else if (setV[i]) pend[i] <= 1'b1;
      else if (clrV[i]) pend[i] <= 1'b0;
    end
  end

  assign irqAN = ~pend[0];
  assign irqBN = ~pend[1];
endmodule

// File: rtl/mailbox_irq.sv
module mailbox_irq
  import mailbox_irq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enA,
  input  logic          wrA,
  input  logic          oeA,
  input  logic          busyA,
  input  logic [AW-1:0] addrA,
  input  logic [DW-1:0] wdataA,
  output logic [DW-1:0] rdataA,
  output logic          irqAN,
  input  logic          enB,
  input  logic          wrB,
  input  logic          oeB,
  input  logic          busyB,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] wdataB,
  output logic [DW-1:0] rdataB,
  output logic          irqBN
);
  strobe_t stb;

  mailbox_ctrl #(.AW(AW)) u_ctrl (
    .enA(enA), .wrA(wrA), .oeA(oeA), .busyA(busyA), .addrA(addrA),
    .enB(enB), .wrB(wrB), .oeB(oeB), .busyB(busyB), .addrB(addrB),
    .stb(stb)
  );

  mailbox_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addrA(addrA), .wdataA(wdataA), .addrB(addrB), .wdataB(wdataB),
    .rdataA(rdataA), .rdataB(rdataB), .irqAN(irqAN), .irqBN(irqBN)
  );
endmodule

// File: rtl/mailbox_irq_chk.sv
module mailbox_irq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          enA,
  input logic          wrA,
  input logic          oeA,
  input logic          busyA,
  input logic [AW-1:0] addrA,
  input logic          irqAN,
  input logic          enB,
  input logic          wrB,
  input logic          oeB,
  input logic          busyB,
  input logic [AW-1:0] addrB,
  input logic          irqBN
);
  localparam logic [AW-1:0] TOPB = {AW{1'b1}};
  localparam logic [AW-1:0] TOPA = TOPB - 1'b1;

  logic aWrB, aRdB, bRdB, bWrA, aRdA;
  always_comb begin
    aWrB = enA & wrA & (addrA == TOPB);
    aRdB = enA & oeA & ~wrA & (addrA == TOPB);
    bRdB = enB & oeB & ~wrB & (addrB == TOPB);
    bWrA = enB & wrB & (addrB == TOPA);
    aRdA = enA & oeA & ~wrA & (addrA == TOPA);
  end

  // R1: reset leaves both interrupts pending
  p_reset_pend_r1: assert property (@(posedge clk) !rstN |=> (!irqAN && !irqBN));

  // R2: unblocked write into the other mailbox raises its interrupt
  p_set_b_r2: assert property (@(posedge clk) disable iff (!rstN)
    (aWrB && !busyA) |=> !irqBN);
  p_set_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bWrA && !busyB) |=> !irqAN);

  // R3: owner read clears, when nothing raises it in the same cycle
  p_clr_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bRdB && !busyB && !(aWrB && !busyA)) |=> irqBN);

  // R4: a read by the other port leaves the interrupt alone
  p_peek_r4: assert property (@(posedge clk) disable iff (!rstN)
    (aRdB && !enB) |=> $stable(irqBN));

  // R5: busy blocks the raise
  p_busy_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (aWrB && busyA && !enB) |=> $stable(irqBN));

  // R6: busy blocks the acknowledge
  p_busy_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (aRdA && busyA && !enB) |=> $stable(irqAN));

  // R8: raise and acknowledge together leave the interrupt pending
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aWrB && !busyA && bRdB && !busyB) |=> !irqBN);
endmodule

bind mailbox_irq mailbox_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN),
  .enA(enA), .wrA(wrA), .oeA(oeA), .busyA(busyA), .addrA(addrA), .irqAN(irqAN),
  .enB(enB), .wrB(wrB), .oeB(oeB), .busyB(busyB), .addrB(addrB), .irqBN(irqBN)
);

// File: tb/tb_mailbox_irq.sv
`timescale 1ns/1ps
module tb_mailbox_irq;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [AW-1:0] MB = 6'd63;   // port B mailbox
  localparam logic [AW-1:0] MA = 6'd62;   // port A mailbox

  typedef struct packed {
    logic en, wr, oe, busy;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } portIn_t;

  typedef struct packed {
    portIn_t a;
    portIn_t b;
    logic    expA;   // expected irqAN after the edge
    logic    expB;   // expected irqBN after the edge
    logic [3:0] req;
  } vec_t;

  function automatic portIn_t rdOp(logic [AW-1:0] ad, logic bz, logic oe);
    rdOp = '{en: 1'b1, wr: 1'b0, oe: oe, busy: bz, addr: ad, data: '0};
  endfunction
  function automatic portIn_t wrOp(logic [AW-1:0] ad, logic [DW-1:0] d, logic bz, logic en);
    wrOp = '{en: en, wr: 1'b1, oe: 1'b0, busy: bz, addr: ad, data: d};
  endfunction
  localparam portIn_t IDLE = '{en: 1'b0, wr: 1'b0, oe: 1'b0, busy: 1'b0, addr: '0, data: '0};

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{rdOp(MA, 0, 1), IDLE,                     1'b1, 1'b0, 4'd3},  // R3 A acknowledges
    '{IDLE,           rdOp(MB, 0, 1),           1'b1, 1'b1, 4'd3},  // R3 B acknowledges
    '{wrOp(MB, 16'hBEEF, 0, 1), IDLE,           1'b1, 1'b0, 4'd2},  // R2 A raises B
    '{rdOp(MB, 0, 1), IDLE,                     1'b1, 1'b0, 4'd4},  // R4 A peeks at B box
    '{IDLE,           rdOp(MB, 1, 1),           1'b1, 1'b0, 4'd6},  // R6 busy blocks clear
    '{IDLE,           rdOp(MB, 0, 1),           1'b1, 1'b1, 4'd3},  // R3
    '{IDLE,           wrOp(MA, 16'hCAFE, 1, 1), 1'b1, 1'b1, 4'd5},  // R5 busy blocks set
    '{IDLE,           wrOp(MA, 16'hCAFE, 0, 1), 1'b0, 1'b1, 4'd2},  // R2 B raises A
    '{rdOp(MA, 0, 0), IDLE,                     1'b0, 1'b1, 4'd7},  // R7 oe low: no clear
    '{rdOp(MA, 0, 1), IDLE,                     1'b1, 1'b1, 4'd3},  // R3
    '{wrOp(MA, 16'h1111, 0, 1), IDLE,           1'b1, 1'b1, 4'd10}, // R10 own box write
    '{wrOp(MB, 16'h0BAD, 0, 0), IDLE,           1'b1, 1'b1, 4'd7}   // R7 en low: no set
  };

  logic clk = 1'b0;
  logic rstN;
  logic enA, wrA, oeA, busyA, enB, wrB, oeB, busyB;
  logic [AW-1:0] addrA, addrB;
  logic [DW-1:0] wdataA, wdataB, rdataA, rdataB;
  logic irqAN, irqBN;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mailbox_irq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN),
    .enA(enA), .wrA(wrA), .oeA(oeA), .busyA(busyA), .addrA(addrA),
    .wdataA(wdataA), .rdataA(rdataA), .irqAN(irqAN),
    .enB(enB), .wrB(wrB), .oeB(oeB), .busyB(busyB), .addrB(addrB),
    .wdataB(wdataB), .rdataB(rdataB), .irqBN(irqBN)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(portIn_t a, portIn_t b);
    enA = a.en; wrA = a.wr; oeA = a.oe; busyA = a.busy; addrA = a.addr; wdataA = a.data;
    enB = b.en; wrB = b.wr; oeB = b.oe; busyB = b.busy; addrB = b.addr; wdataB = b.data;
  endtask

  // apply at negedge, let one rising edge pass, come back to a negedge
  task automatic step(portIn_t a, portIn_t b);
    drive(a, b);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    drive(IDLE, IDLE);
    repeat (3) @(negedge clk);
    chk("R1 irqAN in reset", {15'd0, irqAN}, 16'd0);
    chk("R1 irqBN in reset", {15'd0, irqBN}, 16'd0);
    chk("R1 rdataA in reset", rdataA, 16'd0);
    chk("R1 rdataB in reset", rdataB, 16'd0);
    rstN = 1'b1;
    step(IDLE, IDLE);
    chk("R1 irqAN after reset", {15'd0, irqAN}, 16'd0);
    chk("R1 irqBN after reset", {15'd0, irqBN}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].a, VECS[i].b);
      chk($sformatf("R%0d vec %0d irqAN", VECS[i].req, i), {15'd0, irqAN}, {15'd0, VECS[i].expA});
      chk($sformatf("R%0d vec %0d irqBN", VECS[i].req, i), {15'd0, irqBN}, {15'd0, VECS[i].expB});
    end

    // R9 / R7: B box holds the first message, not the disabled write
    step(IDLE, rdOp(MB, 0, 1));
    chk("R9 rdataB mailbox word", rdataB, 16'hBEEF);
    chk("R7 irqBN unchanged", {15'd0, irqBN}, 16'd1);
    // R9 / R10: own-box write was stored
    step(rdOp(MA, 0, 1), IDLE);
    chk("R9 rdataA own box", rdataA, 16'h1111);
    // R9: ordinary word crosses ports, registered output
    step(wrOp(6'd5, 16'h1234, 0, 1), IDLE);
    step(IDLE, rdOp(6'd5, 0, 1));
    chk("R9 rdataB ordinary word", rdataB, 16'h1234);

    // R8: raise and acknowledge on the same edge
    step(wrOp(MB, 16'h2222, 0, 1), rdOp(MB, 0, 1));
    chk("R8 set wins irqBN", {15'd0, irqBN}, 16'd0);
    step(IDLE, rdOp(MB, 0, 1));
    chk("R3 clear after collision", {15'd0, irqBN}, 16'd1);
    chk("R9 new message", rdataB, 16'h2222);

    // R1: a later reset re-arms both interrupts
    rstN = 1'b0;
    step(IDLE, IDLE);
    chk("R1 irqAN re-reset", {15'd0, irqAN}, 16'd0);
    chk("R1 irqBN re-reset", {15'd0, irqBN}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule